// File: doc/BRIEF.md
# Multi-Mode System Clock Divide Controller

This block lowers the effective system clock rate without touching the clock itself. It produces a clock-enable that is held high in undivided operation. While dividing, the enable becomes a one-cycle pulse, once every N cycles, where N is a power of two picked from a small table. Downstream logic qualifies its registers with this enable.

A single 8-bit control register, written through a simple write strobe and always visible on a readback bus, selects the divisor and one of four entry/exit policies. The policies are:

- Undivided.
- Immediate: divide now, stop on a wakeup.
- Delayed: start and stop on millisecond ticks, or, when the millisecond interrupt is disabled, stop on a counter overflow that follows a wakeup.
- Manual: divide now, stop only on a write.

The readback mode field always reports the live policy. It falls back to 00 when the block leaves division by itself.

Top module: `clkdiv_ctrl`

## Requirements
- R1: Register layout: mode field in bits [5:4], divisor code in bits [2:0]. Bits 7, 6 and 3 read as 0 whatever was written. The register resets to 8'h00 and reads back the mode and divisor last written unless an automatic exit has cleared the mode.
- R2: With mode 00 the enable is high in every cycle.
- R3: Mode 01 divides from the cycle after the write. A wakeup pulse returns the block to mode 00, with the readback showing 00 and the enable held high.
- R4: Mode 10 with the millisecond interrupt enabled keeps the enable high until the first millisecond tick. It divides after that tick and returns to mode 00 on the next tick.
- R5: Mode 10 with the millisecond interrupt disabled begins dividing on the first tick. Later ticks are then ignored, and so is an overflow that comes before any wakeup. An overflow that arrives after a wakeup seen during division returns the block to mode 00.
- R6: Mode 11 divides from the cycle after the write. Wakeups, ticks and overflows leave it dividing, with the readback unchanged.
- R7: Divisor codes 0 to 7 select N = 2, 4, 8, 16, 32, 1024, 2048, 4096. Once division starts, the enable is a single-cycle pulse in the Nth cycle and then every N cycles.
- R8: A register write that coincides with an automatic exit event wins: the written mode and divisor take effect.
- R9: Writing mode 00 leaves division at once from any mode, delay mode included.
- R10: In mode 10 the readback shows 10 both while waiting for the first tick and while dividing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register readback |
| wake | input | 1 | Wakeup event pulse |
| ms_tick | input | 1 | Millisecond tick pulse |
| ms_irq_en | input | 1 | Millisecond interrupt enable level |
| ms_ovf | input | 1 | Millisecond counter overflow pulse |
| clk_en | output | 1 | Clock enable, high every cycle when undivided |

## Verification
The assertions assume that wake, ms_tick and ms_ovf are single-cycle event pulses. They also assume that ms_irq_en is a level that stays stable while a delayed division is running, so the exit rule does not switch partway through. The stimulus raises each event for exactly one cycle between register writes, changes the interrupt enable only while the block is idle, and applies the same-cycle write-versus-exit case only as a deliberate directed test.

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl #(
  parameter int CNT_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       wake,
  input  logic       ms_tick,
  input  logic       ms_irq_en,
  input  logic       ms_ovf,
  output logic       clk_en
);

  localparam logic [1:0] M_NORM = 2'b00;
  localparam logic [1:0] M_IMM  = 2'b01;
  localparam logic [1:0] M_DLY  = 2'b10;
  localparam logic [1:0] M_MAN  = 2'b11;

  logic [1:0]       mode_q;
  logic [2:0]       sel_q;
  logic             run_q, arm_q, woke_q;
  logic [CNT_W-1:0] cnt_q, lim;
  logic             auto_exit, start_tick;

  wire [1:0] wmode = wr_data[5:4];

  always_comb begin
    if (sel_q < 3'd5) lim = CNT_W'((32'd2 << sel_q) - 32'd1);
    else              lim = CNT_W'((32'd1024 << (sel_q - 3'd5)) - 32'd1);
  end

  assign start_tick = (mode_q == M_DLY) && arm_q && ms_tick;

  always_comb begin
    case (mode_q)
      M_IMM:   auto_exit = wake;
      M_DLY:   auto_exit = run_q && (ms_irq_en ? ms_tick : (woke_q && ms_ovf));
      default: auto_exit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_NORM;
      sel_q  <= 3'd0;
      run_q  <= 1'b0;
      arm_q  <= 1'b0;
      woke_q <= 1'b0;
    end else if (wr_en) begin
      mode_q <= wmode;
      sel_q  <= wr_data[2:0];
      run_q  <= wmode[0];
      arm_q  <= (wmode == M_DLY);
      woke_q <= 1'b0;
    end else if (auto_exit) begin
      mode_q <= M_NORM;
      run_q  <= 1'b0;
      woke_q <= 1'b0;
    end else begin
      if (start_tick) begin
        arm_q <= 1'b0;
        run_q <= 1'b1;
      end
      if (mode_q == M_DLY && run_q && !ms_irq_en && wake) woke_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wr_en || !run_q || cnt_q == lim) cnt_q <= '0;
    else                                          cnt_q <= cnt_q + 1'b1;
  end

  assign clk_en  = !run_q || (cnt_q == lim);
  assign rd_data = {2'b00, mode_q, 1'b0, sel_q};

  a_r2_normal_en: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[5:4] == M_NORM) |-> clk_en);

  a_r3_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_data[5:4] == M_IMM && wake) |=> (rd_data[5:4] == M_NORM));

  a_r4_tick_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && mode_q == M_DLY && run_q && ms_irq_en && ms_tick) |=> (rd_data[5:4] == M_NORM && clk_en));

  a_r6_manual_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_data[5:4] == M_MAN) |=> (rd_data[5:4] == M_MAN));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && clk_en && !wr_en) |=> !clk_en);

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[5:4] == $past(wr_data[5:4]) && rd_data[2:0] == $past(wr_data[2:0])));

endmodule

// File: tb/test_clkdiv_ctrl.sv
module test_clkdiv_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       wake = 1'b0, ms_tick = 1'b0, ms_irq_en = 1'b0, ms_ovf = 1'b0;
  logic       clk_en;

  int n_chk = 0;
  int n_bad = 0;

  localparam int unsigned VEC_DIV [8] = '{2, 4, 8, 16, 32, 1024, 2048, 4096};

  always #4 clk = ~clk;

  clkdiv_ctrl i_clkdiv_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .wake(wake), .ms_tick(ms_tick), .ms_irq_en(ms_irq_en), .ms_ovf(ms_ovf), .clk_en(clk_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_wake;
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
  endtask

  task automatic pulse_tick;
    @(negedge clk); ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
  endtask

  task automatic pulse_ovf;
    @(negedge clk); ms_ovf = 1'b1;
    @(negedge clk); ms_ovf = 1'b0;
  endtask

  // Called right after the starting edge: first pulse at index N-1, then gap N.
  task automatic period(input string req, input int unsigned n);
    int first = -1;
    int gap = 0;
    for (int i = 0; i < 5000; i++) begin
      if (clk_en) begin first = i; break; end
      @(negedge clk);
    end
    for (int j = 1; j < 5000; j++) begin
      @(negedge clk);
      if (clk_en) begin gap = j; break; end
    end
    chk(first == int'(n) - 1, {req, " first pulse"}, first, n - 1);
    chk(gap == int'(n), {req, " pulse gap"}, gap, n);
  endtask

  task automatic steady(input string req, input int k);
    bit ok = 1'b1;
    for (int i = 0; i < k; i++) begin
      if (!clk_en) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, {req, " enable held high"}, ok, 1);
  endtask

  task automatic rd(input string req, input logic [7:0] exp);
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R1 reset value", 8'h00);
    steady("R2 reset normal mode", 8);

    // Table walk: manual mode with every divisor code (R7)
    for (int v = 0; v < 8; v++) begin
      wr(8'h30 | 8'(v));
      rd("R1 readback", 8'h30 | 8'(v));
      period("R7 divisor", VEC_DIV[v]);
    end

    wr(8'hFF);
    rd("R1 reserved bits read zero", 8'h37);
    wr(8'h00);

    // Manual ignores events (R6), write of 00 exits (R9)
    wr(8'h31);
    pulse_wake; pulse_tick; pulse_ovf;
    rd("R6 manual keeps mode", 8'h31);
    wr(8'h31);
    period("R6 still dividing", 4);
    wr(8'h00);
    rd("R9 manual exit by write", 8'h00);
    steady("R9 normal after manual", 6);

    // Immediate (R3)
    wr(8'h11);
    rd("R3 immediate readback", 8'h11);
    period("R3 immediate divides", 4);
    pulse_wake;
    rd("R3 wake exit readback", 8'h01);
    steady("R3 normal after wake", 6);

    // Delay with interrupt enabled (R4, R10)
    ms_irq_en = 1'b1;
    wr(8'h20);
    rd("R10 delay waiting readback", 8'h20);
    steady("R10 waiting undivided", 5);
    pulse_tick;
    rd("R10 delay dividing readback", 8'h20);
    period("R4 divides after tick", 2);
    pulse_tick;
    rd("R4 second tick exit", 8'h00);
    steady("R4 normal after exit", 6);

    // Delay with interrupt disabled (R5)
    ms_irq_en = 1'b0;
    wr(8'h21);
    steady("R5 waiting undivided", 4);
    pulse_tick;
    period("R5 divides after masked tick", 4);
    pulse_tick;
    rd("R5 later tick ignored", 8'h21);
    pulse_ovf;
    rd("R5 overflow before wake ignored", 8'h21);
    pulse_wake;
    rd("R5 wake alone keeps mode", 8'h21);
    pulse_ovf;
    rd("R5 overflow after wake exits", 8'h01);
    steady("R5 normal after exit", 6);

    // Write leaves delay mode (R9)
    ms_irq_en = 1'b1;
    wr(8'h22);
    pulse_tick;
    wr(8'h02);
    rd("R9 delay exit by write", 8'h02);
    steady("R9 normal after delay", 6);

    // Write wins over a same-cycle wakeup (R8)
    wr(8'h10);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h32; wake = 1'b1;
    @(negedge clk); wr_en = 1'b0; wake = 1'b0;
    rd("R8 write beats wake", 8'h32);
    period("R8 new divisor active", 8);

    // Write wins over a same-cycle exit tick in delay mode (R8)
    wr(8'h20);
    pulse_tick;
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h11; ms_tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; ms_tick = 1'b0;
    rd("R8 write beats tick", 8'h11);
    period("R8 immediate after write", 4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule